// File: doc/BRIEF.md
# LIN Event Status and Interrupt Combiner

This block sits beside a LIN controller and gathers the events it reports into sticky status flags. Single-cycle pulses mark three outcomes: an identifier was received, a response was sent, or a response was received. Eight further pulses report error conditions. Each flag stays set until software clears it by writing a 1 to its bit through a small register port. A per-flag enable register controls two registered interrupt lines. One line reports successful traffic. The other reports any error.

When an identifier arrives, the block also classifies it. The four diagnostic identifiers 0x3C to 0x3F get a 3-bit frame status code, and every other identifier reads as "not special". No other identifier filtering is done. Reads are combinational from the address. A write takes effect on the clock edge where `reg_wr` is high.

Top module: `lin_event_irq`

## Requirements
- R1: After reset, every register reads 0x00 and both interrupt outputs are low.
- R2: A pulse on `ev_rx_ok`, `ev_tx_ok` or `ev_id_ok` sets status bit 0, 1 or 2 of address 0 on the next edge. The bit stays set with no further event.
- R3: Writing address 0 with a 1 in bit 0, 1 or 2 clears that flag. A 0 in that position leaves the flag unchanged.
- R4: If an event pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R5: Address 2 holds the error flags. Bits 0 to 7 are bit, checksum, parity, sync, framing, overrun, timeout and abort. A pulse on `ev_err[i]` sets bit i. Writing a 1 to a bit clears it. Writing a 0 leaves it unchanged.
- R6: Status bit 3 reads as the OR of the eight error flags. Writes to address 0 do not change it.
- R7: Address 1 is the enable register. Bits 3:0 are read/write and line up with status bits 3:0. Bits 7:4 read 0.
- R8: `irq_evt` is the registered OR of status bits 2:0 ANDed with enable bits 2:0. It rises or falls one edge after the flags or enables change.
- R9: `irq_err` is the registered AND of enable bit 3 and the error summary. It changes one edge after its inputs change.
- R10: Status bits 6:4 hold the frame status. On `ev_id_ok`, an identifier of 0x3C, 0x3D, 0x3E or 0x3F loads 100, 101, 110 or 111. Any other identifier loads 000. Without `ev_id_ok` the field holds its value, and clearing flags does not change it.
- R11: Address 3 and status bit 7 read 0. Writes to address 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_id_ok | input | 1 | Identifier received pulse |
| ev_tx_ok | input | 1 | Response transmitted pulse |
| ev_rx_ok | input | 1 | Response received pulse |
| ev_err | input | 8 | Error event pulses, one per error flag |
| rx_ident | input | 6 | Received identifier, valid with `ev_id_ok` |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_evt | output | 1 | Interrupt for successful events |
| irq_err | output | 1 | Interrupt for errors |

## Verification
The assertions assume that `rx_ident` is meaningful only in a cycle where `ev_id_ok` is high. They also assume that a write clears flags only at address 0 or address 2 and never at address 1. Event inputs are assumed to be single-cycle pulses driven between clock edges. The bench drives each pulse and each write strobe at a falling edge and removes it at the next falling edge, so each one covers exactly one rising edge. It also changes `rx_ident` only together with an identifier event.

// File: rtl/lin_irq_pkg.sv
package lin_irq_pkg;

    localparam int REG_W    = 8;
    localparam int ADDR_W   = 2;
    localparam int OK_N     = 3;
    localparam int EN_N     = 4;
    localparam int FST_W    = 3;

    localparam logic [ADDR_W-1:0] ADR_STAT = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_EN   = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_ERR  = 2'd2;

    // bit positions inside the status byte
    localparam int ST_RX  = 0;
    localparam int ST_TX  = 1;
    localparam int ST_ID  = 2;
    localparam int ST_ERR = 3;
    localparam int ST_FS  = 4;

    typedef struct packed {
        logic [EN_N-1:0] en;
    } ctl_state_t;

    typedef struct packed {
        logic evt;
        logic err;
    } irq_state_t;

endpackage

// File: rtl/lin_sticky_bank.sv
module lin_sticky_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);

    typedef struct packed {
        logic [N-1:0] flag;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
    end

    // one independent set-dominant cell per bit
    for (genvar i = 0; i < N; i++) begin : g_cell
        logic nxt_d;
        always_comb begin
            nxt_d = set_i[i] | (st_q.flag[i] & ~clr_i[i]);
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q.flag[i] <= 1'b0;
            else        st_q.flag[i] <= nxt_d;
        end
    end

    assign flag_o = st_q.flag;

endmodule

// File: rtl/lin_diag_id_decode.sv
module lin_diag_id_decode
    import lin_irq_pkg::*;
#(
    parameter int ID_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [ID_W-1:0] ident_i,
    output logic [FST_W-1:0] fstat_o
);

    localparam int HI_W = ID_W - 2;

    typedef struct packed {
        logic [FST_W-1:0] code;
    } dec_t;

    dec_t st_d, st_q;
    logic is_diag;

    always_comb begin
        is_diag = (ident_i[ID_W-1:2] == {HI_W{1'b1}});
        st_d    = st_q;
        if (load_i) begin
            if (is_diag) st_d.code = {1'b1, ident_i[1:0]};
            else         st_d.code = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fstat_o = st_q.code;

endmodule

// File: rtl/lin_irq_merge.sv
module lin_irq_merge
    import lin_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OK_N-1:0] ok_i,
    input  logic            err_sum_i,
    input  logic [EN_N-1:0] en_i,
    output logic            irq_evt_o,
    output logic            irq_err_o
);

    irq_state_t st_d, st_q;

    always_comb begin
        st_d.evt = |(ok_i & en_i[OK_N-1:0]);
        st_d.err = err_sum_i & en_i[ST_ERR];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_evt_o = st_q.evt;
    assign irq_err_o = st_q.err;

endmodule

// File: rtl/lin_event_irq.sv
module lin_event_irq
    import lin_irq_pkg::*;
#(
    parameter int ID_W  = 6,
    parameter int ERR_N = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_id_ok,
    input  logic              ev_tx_ok,
    input  logic              ev_rx_ok,
    input  logic [ERR_N-1:0]  ev_err,
    input  logic [ID_W-1:0]   rx_ident,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq_evt,
    output logic              irq_err
);

    ctl_state_t        ctl_d, ctl_q;
    logic [OK_N-1:0]   ok_set, ok_clr, ok_q;
    logic [ERR_N-1:0]  err_clr, err_q;
    logic [EN_N-1:0]   en_q;
    logic [FST_W-1:0]  fstat_q;
    logic              err_sum;
    logic              wr_stat, wr_err;

    always_comb begin
        wr_stat = reg_wr && (reg_addr == ADR_STAT);
        wr_err  = reg_wr && (reg_addr == ADR_ERR);
        ok_set  = {ev_id_ok, ev_tx_ok, ev_rx_ok};
        ok_clr  = wr_stat ? reg_wdata[OK_N-1:0] : '0;
        err_clr = wr_err  ? reg_wdata[ERR_N-1:0] : '0;
        err_sum = |err_q;
        ctl_d   = ctl_q;
        if (reg_wr && (reg_addr == ADR_EN)) ctl_d.en = reg_wdata[EN_N-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign en_q = ctl_q.en;

    lin_sticky_bank #(.N(OK_N)) u_ok_bank (
        .clk(clk), .rst_n(rst_n), .set_i(ok_set), .clr_i(ok_clr), .flag_o(ok_q)
    );

    lin_sticky_bank #(.N(ERR_N)) u_err_bank (
        .clk(clk), .rst_n(rst_n), .set_i(ev_err), .clr_i(err_clr), .flag_o(err_q)
    );

    lin_diag_id_decode #(.ID_W(ID_W)) u_id_dec (
        .clk(clk), .rst_n(rst_n), .load_i(ev_id_ok), .ident_i(rx_ident),
        .fstat_o(fstat_q)
    );

    lin_irq_merge u_irq (
        .clk(clk), .rst_n(rst_n), .ok_i(ok_q), .err_sum_i(err_sum), .en_i(en_q),
        .irq_evt_o(irq_evt), .irq_err_o(irq_err)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADR_STAT: begin
                reg_rdata[OK_N-1:0]           = ok_q;
                reg_rdata[ST_ERR]             = err_sum;
                reg_rdata[ST_FS +: FST_W]     = fstat_q;
            end
            ADR_EN:   reg_rdata[EN_N-1:0]     = en_q;
            ADR_ERR:  reg_rdata[ERR_N-1:0]    = err_q;
            default:  reg_rdata               = '0;
        endcase
    end

endmodule

// File: rtl/lin_event_irq_chk.sv
module lin_event_irq_chk
    import lin_irq_pkg::*;
#(
    parameter int ID_W  = 6,
    parameter int ERR_N = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_id_ok,
    input logic              ev_tx_ok,
    input logic              ev_rx_ok,
    input logic [ERR_N-1:0]  ev_err,
    input logic [ID_W-1:0]   rx_ident,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [REG_W-1:0]  reg_rdata,
    input logic              irq_evt,
    input logic              irq_err,
    input logic [OK_N-1:0]   ok_q,
    input logic [ERR_N-1:0]  err_q,
    input logic [EN_N-1:0]   en_q,
    input logic [FST_W-1:0]  fstat_q
);

    // R2
    rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_ok |=> ok_q[ST_RX]);

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_tx_ok && reg_wr && reg_addr == ADR_STAT && reg_wdata[ST_TX]) |=> ok_q[ST_TX]);

    // R3
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_q[ST_RX] && !(reg_wr && reg_addr == ADR_STAT && reg_wdata[ST_RX])) |=> ok_q[ST_RX]);

    // R5
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_err != '0) |=> ((err_q & $past(ev_err)) == $past(ev_err)));

    // R6
    err_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADR_STAT) |-> (reg_rdata[ST_ERR] == (err_q != '0)));

    // R8
    irq_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_evt == $past(|(ok_q & en_q[OK_N-1:0])));

    // R9
    irq_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err == $past(en_q[ST_ERR] && (err_q != '0)));

    // R10
    fstat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_id_ok |=> $stable(fstat_q));

    // R10
    fstat_diag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_id_ok && rx_ident[ID_W-1:2] == '1) |=> (fstat_q == {1'b1, $past(rx_ident[1:0])}));

endmodule

bind lin_event_irq lin_event_irq_chk #(.ID_W(ID_W), .ERR_N(ERR_N)) u_chk (
    .clk(clk), .rst_n(rst_n), .ev_id_ok(ev_id_ok), .ev_tx_ok(ev_tx_ok),
    .ev_rx_ok(ev_rx_ok), .ev_err(ev_err), .rx_ident(rx_ident), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_evt(irq_evt), .irq_err(irq_err), .ok_q(ok_q), .err_q(err_q),
    .en_q(en_q), .fstat_q(fstat_q)
);

// File: tb/lin_event_irq_test.sv
`timescale 1ns/100ps
module lin_event_irq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_id_ok = 1'b0, ev_tx_ok = 1'b0, ev_rx_ok = 1'b0;
    logic [7:0] ev_err = '0;
    logic [5:0] rx_ident = '0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_evt, irq_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    lin_event_irq uut (
        .clk(clk), .rst_n(rst_n), .ev_id_ok(ev_id_ok), .ev_tx_ok(ev_tx_ok),
        .ev_rx_ok(ev_rx_ok), .ev_err(ev_err), .rx_ident(rx_ident), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_evt(irq_evt), .irq_err(irq_err)
    );

    typedef struct packed {
        logic [2:0] ev;      // {id, tx, rx}
        logic [7:0] err;
        logic [5:0] ident;
        logic [7:0] exp_st;
        logic [7:0] exp_er;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t TBL [NV] = '{
        vec_t'{3'b001, 8'h00, 6'h00, 8'h01, 8'h00},
        vec_t'{3'b100, 8'h00, 6'h3C, 8'h44, 8'h00},
        vec_t'{3'b010, 8'h05, 6'h3F, 8'h4A, 8'h05},
        vec_t'{3'b100, 8'h00, 6'h3F, 8'h74, 8'h00},
        vec_t'{3'b100, 8'h00, 6'h3B, 8'h04, 8'h00},
        vec_t'{3'b000, 8'h80, 6'h00, 8'h08, 8'h80},
        vec_t'{3'b111, 8'h00, 6'h3D, 8'h57, 8'h00},
        vec_t'{3'b100, 8'h00, 6'h1F, 8'h04, 8'h00}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse(input logic [2:0] ev, input logic [7:0] er, input logic [5:0] id);
        @(negedge clk);
        {ev_id_ok, ev_tx_ok, ev_rx_ok} = ev; ev_err = er; rx_ident = id;
        @(negedge clk);
        {ev_id_ok, ev_tx_ok, ev_rx_ok} = '0; ev_err = '0;
    endtask

    task automatic clear_all();
        wr(2'd0, 8'h07);
        wr(2'd2, 8'hFF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v); check("R1", v, 8'h00);
        end
        check("R1 irq", {6'b0, irq_evt, irq_err}, 8'h00);

        // table walk: R2 R5 R6 R10
        for (int i = 0; i < NV; i++) begin
            pulse(TBL[i].ev, TBL[i].err, TBL[i].ident);
            rd(2'd0, v); check("R2/R6/R10 status", v, TBL[i].exp_st);
            rd(2'd2, v); check("R5 error", v, TBL[i].exp_er);
            clear_all();
        end
        // R10 frame status survives flag clearing (last id 0x1F gives 000, load 0x3E)
        pulse(3'b100, 8'h00, 6'h3E);
        wr(2'd0, 8'h07);
        rd(2'd0, v); check("R10 hold", v, 8'h60);

        // R7 enable register
        wr(2'd1, 8'hFF);
        rd(2'd1, v); check("R7", v, 8'h0F);
        wr(2'd1, 8'h00);

        // R3 write 0 keeps, write 1 clears
        pulse(3'b001, 8'h00, 6'h00);
        wr(2'd0, 8'h00);
        rd(2'd0, v); check("R3 keep", v & 8'h0F, 8'h01);
        wr(2'd0, 8'h01);
        rd(2'd0, v); check("R3 clear", v & 8'h0F, 8'h00);

        // R4 set beats clear
        @(negedge clk);
        ev_tx_ok = 1'b1; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h02;
        @(negedge clk);
        ev_tx_ok = 1'b0; reg_wr = 1'b0;
        rd(2'd0, v); check("R4", v & 8'h0F, 8'h02);
        clear_all();

        // R8 interrupt timing
        wr(2'd1, 8'h01);
        @(negedge clk);
        ev_rx_ok = 1'b1;
        @(negedge clk);
        ev_rx_ok = 1'b0;
        check("R8 lag", {7'b0, irq_evt}, 8'h00);
        @(negedge clk);
        check("R8 rise", {7'b0, irq_evt}, 8'h01);
        wr(2'd1, 8'h00);
        check("R8 still", {7'b0, irq_evt}, 8'h01);
        @(negedge clk);
        check("R8 drop", {7'b0, irq_evt}, 8'h00);
        clear_all();

        // R9 error interrupt, R6 read-only summary
        wr(2'd1, 8'h08);
        pulse(3'b000, 8'h08, 6'h00);
        @(negedge clk);
        check("R9 rise", {6'b0, irq_evt, irq_err}, 8'h01);
        wr(2'd0, 8'h08);
        rd(2'd0, v); check("R6 ro", v & 8'h0F, 8'h08);
        wr(2'd2, 8'h01);
        rd(2'd2, v); check("R5 w0", v, 8'h08);
        wr(2'd2, 8'h08);
        @(negedge clk);
        check("R9 drop", {7'b0, irq_err}, 8'h00);
        wr(2'd1, 8'h00);

        // R11 unused address
        wr(2'd3, 8'hFF);
        rd(2'd3, v); check("R11", v, 8'h00);
        rd(2'd1, v); check("R11 en untouched", v, 8'h00);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule